// File: doc/BRIEF.md
# First-Message Route Capture

This block sits behind a message decoder at a track-side reader. It watches the decoder's message-valid pulse and stores the 6-bit route number carried by one message: the first good message from the lead vehicle after the track section becomes occupied. After that message is taken, a sticky first-message flag locks the stored route. Later messages cannot change it until the track section empties, a master reset is applied, or both.

The track, lead-vehicle, message and route inputs come from another timing domain, so each passes through a two-flop synchroniser. Capture is not done at the message edge. A clocked counter first waits a programmed delay and then raises a data strobe for a programmed width. Both times are given in microseconds and converted to clock cycles from the clock frequency parameter. The route register loads on the first cycle of the strobe. The flag sets when the strobe ends, and a one-cycle done pulse is issued at the same moment. Route decoding and output drive belong to later blocks.

Top module: `route_first_capture`

## Requirements
- R1: While `rstMaster` is high, and in the cycle after it falls, `routeOut`, `firstMsg`, `strobe` and `captureDone` are all zero.
- R2: A capture starts only on a rising edge of the synchronised `msgIn` seen while the synchronised `trackIn` and `leadIn` are both high and `firstMsg` is low. A message with the lead bit low, or with the track low, leaves every output at zero.
- R3: `strobe` first reads high at the (DELAY_CYC+3)-th falling clock edge after `msgIn` is driven high between edges. This counts two synchroniser stages, one edge-detect cycle and DELAY_CYC delay cycles. It then stays high for exactly WIDTH_CYC cycles, where each count is CLK_HZ/1e6 times its microsecond parameter.
- R4: `routeOut` reads zero until a capture. It takes the synchronised `routeIn` value in the same cycle that `strobe` rises, and it changes at no other time except when cleared to zero. Bits [3:0] carry the units digit and bits [5:4] the tens digit, and are stored unaltered.
- R5: `firstMsg` rises in the cycle after the last strobe cycle. `captureDone` is high for exactly that one cycle.
- R6: While `firstMsg` is high, further messages raise no strobe and leave `routeOut` unchanged.
- R7: A falling edge of the synchronised `trackIn` returns `routeOut` and `firstMsg` to zero.
- R8: If the track falls while a capture is pending (during the delay or the strobe), the capture is abandoned: `firstMsg` never sets for it and `routeOut` ends at zero.
- R9: Asserting `rstMaster` after a capture clears `routeOut` and `firstMsg`, and they stay zero afterwards until a new qualified message arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstMaster | input | 1 | Synchronous active-high master reset, asserted at power-up |
| routeIn | input | ROUTE_W | Route number field from the decoder (asynchronous) |
| trackIn | input | 1 | Track section occupied level (asynchronous) |
| leadIn | input | 1 | Lead-vehicle bit of the current message (asynchronous) |
| msgIn | input | 1 | Message-valid pulse from the decoder (asynchronous) |
| routeOut | output | ROUTE_W | Stored route number, zero when none held |
| firstMsg | output | 1 | Sticky first-message indicator |
| strobe | output | 1 | Delayed data strobe |
| captureDone | output | 1 | One-cycle pulse when the first-message flag sets |

## Verification
The assertions assume that `rstMaster` is already synchronous to `clk`. They also assume that the route and lead inputs stay steady from the message edge until the strobe has risen, so the value stored is the value the message carried. The stimulus changes the inputs only on falling clock edges. It holds the route and lead bits for well past the strobe window of each message. It leaves a gap of many cycles between messages, so each message pulse is seen as one clean rising edge after synchronisation.

// File: rtl/route_cap_pkg.sv
package route_cap_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;     // take the synchronised route field
    logic clear;    // drop route and flag (track emptied)
    logic setFlag;  // lock out later messages
  } capCtl_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2
  } capPhase_t;

endpackage

// File: rtl/rcap_sync.sv
module rcap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/rcap_ctrl.sv
module rcap_ctrl
  import route_cap_pkg::*;
#(
  parameter int DELAY_CYC = 2000,
  parameter int WIDTH_CYC = 2000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    trkS,
  input  logic    leadS,
  input  logic    msgS,
  input  logic    flagQ,
  output capCtl_t ctl,
  output logic    strobe,
  output logic    captureDone
);

  localparam int MAX_CYC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] WID_LAST = CW'(WIDTH_CYC - 1);

  capPhase_t   phase, phaseNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic trkPrev, msgPrev;
  logic trackFall, msgRise, qualified;

  assign trackFall = trkPrev & ~trkS;
  assign msgRise   = msgS & ~msgPrev;
  assign qualified = msgRise & trkS & leadS & ~flagQ;

  always_comb begin
    phaseNxt    = phase;
    cntNxt      = cnt;
    ctl         = '0;
    ctl.clear   = trackFall;
    if (trackFall) begin
      phaseNxt = PH_IDLE;
      cntNxt   = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (qualified) begin
            phaseNxt = PH_DELAY;
            cntNxt   = '0;
          end
        end
        PH_DELAY: begin
          if (!trkS) begin
            phaseNxt = PH_IDLE;
            cntNxt   = '0;
          end else if (cnt == DLY_LAST) begin
            ctl.load = 1'b1;
            phaseNxt = PH_PULSE;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt == WID_LAST) begin
            ctl.setFlag = 1'b1;
            phaseNxt    = PH_IDLE;
            cntNxt      = '0;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        default: begin
          phaseNxt = PH_IDLE;
          cntNxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      trkPrev     <= 1'b0;
      msgPrev     <= 1'b0;
      captureDone <= 1'b0;
    end else begin
      phase       <= phaseNxt;
      cnt         <= cntNxt;
      trkPrev     <= trkS;
      msgPrev     <= msgS;
      captureDone <= ctl.setFlag;
    end
  end

  assign strobe = (phase == PH_PULSE);

endmodule

// File: rtl/rcap_dpath.sv
module rcap_dpath
  import route_cap_pkg::*;
#(
  parameter int ROUTE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  capCtl_t            ctl,
  input  logic [ROUTE_W-1:0] routeS,
  output logic [ROUTE_W-1:0] routeQ,
  output logic               flagQ
);

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      routeQ <= '0;
      flagQ  <= 1'b0;
    end else begin
      if (ctl.load)    routeQ <= routeS;
      if (ctl.setFlag) flagQ  <= 1'b1;
    end
  end

endmodule

// File: rtl/route_first_capture.sv
module route_first_capture
  import route_cap_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DELAY_US = 20,
  parameter int WIDTH_US = 20,
  parameter int ROUTE_W  = 6
) (
  input  logic               clk,
  input  logic               rstMaster,
  input  logic [ROUTE_W-1:0] routeIn,
  input  logic               trackIn,
  input  logic               leadIn,
  input  logic               msgIn,
  output logic [ROUTE_W-1:0] routeOut,
  output logic               firstMsg,
  output logic               strobe,
  output logic               captureDone
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int DELAY_RAW  = CYC_PER_US * DELAY_US;
  localparam int WIDTH_RAW  = CYC_PER_US * WIDTH_US;
  localparam int DELAY_CYC  = (DELAY_RAW > 0) ? DELAY_RAW : 1;
  localparam int WIDTH_CYC  = (WIDTH_RAW > 0) ? WIDTH_RAW : 1;
  localparam int SYNC_W     = ROUTE_W + 3;

  logic [SYNC_W-1:0] rawBus, syncBus;
  logic [ROUTE_W-1:0] routeS;
  logic trkS, leadS, msgS, flagQ;
  capCtl_t ctl;

  assign rawBus = {routeIn, trackIn, leadIn, msgIn};

  rcap_sync #(.WIDTH(SYNC_W), .STAGES(2)) sync_i (
    .clk     (clk),
    .rst     (rstMaster),
    .asyncIn (rawBus),
    .syncOut (syncBus)
  );

  assign {routeS, trkS, leadS, msgS} = syncBus;

  rcap_ctrl #(.DELAY_CYC(DELAY_CYC), .WIDTH_CYC(WIDTH_CYC)) ctrl_i (
    .clk         (clk),
    .rst         (rstMaster),
    .trkS        (trkS),
    .leadS       (leadS),
    .msgS        (msgS),
    .flagQ       (flagQ),
    .ctl         (ctl),
    .strobe      (strobe),
    .captureDone (captureDone)
  );

  rcap_dpath #(.ROUTE_W(ROUTE_W)) dpath_i (
    .clk    (clk),
    .rst    (rstMaster),
    .ctl    (ctl),
    .routeS (routeS),
    .routeQ (routeOut),
    .flagQ  (flagQ)
  );

  assign firstMsg = flagQ;

endmodule

// File: rtl/route_first_capture_chk.sv
module route_first_capture_chk #(
  parameter int ROUTE_W = 6
) (
  input logic               clk,
  input logic               rstMaster,
  input logic [ROUTE_W-1:0] routeOut,
  input logic               firstMsg,
  input logic               strobe,
  input logic               captureDone
);

  // R5: the done pulse coincides with the flag being set
  a_r5_done_implies_flag: assert property (@(posedge clk) disable iff (rstMaster)
    captureDone |-> firstMsg);

  // R5: done lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rstMaster)
    captureDone |=> !captureDone);

  // R5: the flag only rises right after a strobe cycle
  a_r5_flag_after_strobe: assert property (@(posedge clk) disable iff (rstMaster)
    $rose(firstMsg) |-> $past(strobe));

  // R6: a locked capture never strobes again
  a_r6_locked_no_strobe: assert property (@(posedge clk) disable iff (rstMaster)
    firstMsg |-> !strobe);

  // R4: the stored route moves only on a strobe rise or when cleared
  a_r4_route_changes_at_load: assert property (@(posedge clk) disable iff (rstMaster)
    !$stable(routeOut) |-> ($rose(strobe) || routeOut == '0));

  // R4: nothing is held before a capture is under way or done
  a_r4_zero_until_capture: assert property (@(posedge clk) disable iff (rstMaster)
    (!firstMsg && !strobe) |-> routeOut == '0);

  // R7: dropping the flag also drops the route
  a_r7_flag_fall_clears: assert property (@(posedge clk) disable iff (rstMaster)
    $fell(firstMsg) |-> routeOut == '0);

endmodule

bind route_first_capture route_first_capture_chk #(.ROUTE_W(ROUTE_W)) chk_i (
  .clk         (clk),
  .rstMaster   (rstMaster),
  .routeOut    (routeOut),
  .firstMsg    (firstMsg),
  .strobe      (strobe),
  .captureDone (captureDone)
);

// File: tb/route_first_capture_tb_top.sv
`timescale 1ns/1ps
module route_first_capture_tb_top;

  localparam int CLK_HZ = 1_000_000;   // scaled so one us is one cycle
  localparam int DLY    = 20;
  localparam int WID    = 20;
  localparam int RW     = 6;

  logic clk = 1'b0;
  logic rstMaster = 1'b1;
  logic [RW-1:0] routeIn = '0;
  logic trackIn = 1'b0, leadIn = 1'b0, msgIn = 1'b0;
  logic [RW-1:0] routeOut;
  logic firstMsg, strobe, captureDone;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;

  always #5 clk = ~clk;

  route_first_capture #(
    .CLK_HZ(CLK_HZ), .DELAY_US(DLY), .WIDTH_US(WID), .ROUTE_W(RW)
  ) dut_i (
    .clk(clk), .rstMaster(rstMaster), .routeIn(routeIn), .trackIn(trackIn),
    .leadIn(leadIn), .msgIn(msgIn), .routeOut(routeOut), .firstMsg(firstMsg),
    .strobe(strobe), .captureDone(captureDone)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  ph = 0, cnt = 0;
  bit  eFlag = 0, eDone = 0;
  int  eRoute = 0;
  bit  p1Trk = 0, p1Msg = 0, p1Lead = 0; int p1Route = 0;
  bit  sTrk = 0, sMsg = 0, sLead = 0; int sRoute = 0;
  bit  sTrkP = 0, sMsgP = 0;

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rstMaster) begin
      ph = 0; cnt = 0; eFlag = 0; eDone = 0; eRoute = 0;
      p1Trk = 0; p1Msg = 0; p1Lead = 0; p1Route = 0;
      sTrk = 0; sMsg = 0; sLead = 0; sRoute = 0; sTrkP = 0; sMsgP = 0;
    end else begin
      eDone = 0;
      if (sTrkP && !sTrk) begin
        eRoute = 0; eFlag = 0; ph = 0; cnt = 0;
      end else if (ph == 0) begin
        if (sMsg && !sMsgP && sTrk && sLead && !eFlag) begin ph = 1; cnt = 0; end
      end else if (ph == 1) begin
        if (!sTrk) begin ph = 0; cnt = 0; end
        else if (cnt == DLY - 1) begin eRoute = sRoute; ph = 2; cnt = 0; end
        else cnt++;
      end else begin
        if (cnt == WID - 1) begin eFlag = 1; eDone = 1; ph = 0; cnt = 0; end
        else cnt++;
      end
      sTrkP = sTrk; sMsgP = sMsg;
      sTrk = p1Trk; sMsg = p1Msg; sLead = p1Lead; sRoute = p1Route;
      p1Trk = trackIn; p1Msg = msgIn; p1Lead = leadIn; p1Route = int'(routeIn);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R4", int'(routeOut), eRoute, "model routeOut");
      chk("R5", int'(firstMsg), int'(eFlag), "model firstMsg");
      chk("R3", int'(strobe), (ph == 2) ? 1 : 0, "model strobe");
      chk("R5", int'(captureDone), int'(eDone), "model captureDone");
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendMsg(input logic [RW-1:0] r, input logic lead);
    @(negedge clk);
    routeIn = r; leadIn = lead; msgIn = 1'b1;
    idle(WID);
    msgIn = 1'b0;
    idle(35);
    leadIn = 1'b0;
    idle(5);
  endtask

  initial begin
    idle(3);
    // R1: outputs quiet during reset
    chk("R1", int'(routeOut), 0, "reset routeOut");
    chk("R1", int'(firstMsg | strobe | captureDone), 0, "reset flags");
    rstMaster = 1'b0;
    idle(1);
    chk("R1", int'({routeOut, firstMsg, strobe, captureDone}), 0, "after reset release");

    // R2: track low, lead high -> no capture
    sendMsg(6'h13, 1'b1);
    chk("R2", int'(firstMsg), 0, "no capture with track low");
    chk("R2", int'(routeOut), 0, "route with track low");

    // R2: track high, lead low -> no capture
    trackIn = 1'b1; idle(5);
    sendMsg(6'h15, 1'b0);
    chk("R2", int'(firstMsg), 0, "no capture with lead low");
    chk("R2", int'(routeOut), 0, "route with lead low");

    // R3/R4/R5: timed capture of route 13 (tens=1, units=3)
    begin
      int n = 0;
      int w = 0;
      @(negedge clk);
      routeIn = 6'h13; leadIn = 1'b1; msgIn = 1'b1;
      while (strobe !== 1'b1 && n < 200) begin
        @(negedge clk); n++;
        if (n == WID) msgIn = 1'b0;
        if (strobe !== 1'b1) chk("R4", int'(routeOut), 0, "route before strobe");
      end
      chk("R3", n, DLY + 3, "strobe latency");
      chk("R4", int'(routeOut), 'h13, "route at strobe rise");
      while (strobe === 1'b1 && w < 200) begin @(negedge clk); w++; end
      chk("R3", w, WID, "strobe width");
      chk("R5", int'(firstMsg), 1, "flag after strobe");
      chk("R5", int'(captureDone), 1, "done pulse");
      @(negedge clk);
      chk("R5", int'(captureDone), 0, "done one cycle");
      idle(10); leadIn = 1'b0;
    end

    // R6: second message ignored
    sendMsg(6'h20, 1'b1);
    chk("R6", int'(routeOut), 'h13, "route locked");
    chk("R6", int'(firstMsg), 1, "flag stays");

    // R7: track empties clears
    trackIn = 1'b0; idle(5);
    chk("R7", int'(routeOut), 0, "route cleared");
    chk("R7", int'(firstMsg), 0, "flag cleared");

    // route 20 capture after re-occupy
    trackIn = 1'b1; idle(5);
    sendMsg(6'h20, 1'b1);
    chk("R4", int'(routeOut), 'h20, "route 20 captured");

    // R8: cancel during delay
    trackIn = 1'b0; idle(5); trackIn = 1'b1; idle(5);
    @(negedge clk); routeIn = 6'h07; leadIn = 1'b1; msgIn = 1'b1;
    idle(10); trackIn = 1'b0; idle(WID); msgIn = 1'b0; idle(40);
    chk("R8", int'(firstMsg), 0, "cancel in delay flag");
    chk("R8", int'(routeOut), 0, "cancel in delay route");

    // R8: cancel during strobe
    trackIn = 1'b1; idle(5);
    @(negedge clk); routeIn = 6'h09; leadIn = 1'b1; msgIn = 1'b1;
    idle(WID); msgIn = 1'b0; idle(DLY + 8 - WID);
    chk("R8", int'(strobe), 1, "strobe under way");
    trackIn = 1'b0; idle(40);
    chk("R8", int'(firstMsg), 0, "cancel in strobe flag");
    chk("R8", int'(routeOut), 0, "cancel in strobe route");
    leadIn = 1'b0;

    // R9: master reset after capture
    trackIn = 1'b1; idle(5);
    sendMsg(6'h11, 1'b1);
    chk("R9", int'(firstMsg), 1, "captured before reset");
    rstMaster = 1'b1; idle(3); rstMaster = 1'b0; idle(30);
    chk("R9", int'(routeOut), 0, "route after master reset");
    chk("R9", int'(firstMsg), 0, "flag after master reset");

    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule